// File: doc/BRIEF.md
# Endpoint Link Bring-Up Sequencer

This block walks a serial link controller through its start-up as an endpoint, with no software involved. After reset it drives a fixed series of steps. It sets the device-type control to the endpoint code, takes the controller out of reset and turns on the PHY PLL with a multiplier value. It then waits for the PLL to report lock. Link training stays disabled during all of this.

Once the PLL is locked, the block opens a configuration window. While the window is open, writes presented on a small register-write port are forwarded to the controller. A `cfg_done` pulse closes the window. The block then enables link training and watches the training-state code until it reaches the link-up value.

If the caller asks for late configuration when it closes the first window, an application-retry control is raised before training starts. Host requests are then answered with retry responses. After link-up the configuration window reopens. The retry control is cleared only when a second `cfg_done` arrives. Each of the two waits, PLL lock and link-up, has its own programmable timeout. An expired timeout sends the sequencer to a sticky error state. Outbound traffic is permitted only after bring-up is complete and the host has granted bus-master capability.

Top module: `ep_bringup_seq`

## Requirements
- R1: While reset is asserted, `ctl_devtype` is all ones and every other control output is 0. At the first clock edge after reset release, `ctl_devtype` becomes 0, which is the endpoint code.
- R2: The controller reset `ctl_rst_n` goes to 1 one edge after the endpoint code is set. At the following edge `pll_en` goes to 1 and `pll_mult` takes the multiplier parameter, whose default is 0x1C9.
- R3: While `pll_locked` is 0 the sequencer waits. At the edge that samples `pll_locked` = 1, `cfg_open` goes to 1.
- R4: If `pll_locked` stays 0, `err` goes to 1 at the (pll_tmo+1)-th edge after the edge that set `pll_en`.
- R5: A write presented on `cfg_in_*` at an edge where `cfg_open` is 1 appears on `cfg_wr_*` after that edge. A write presented while `cfg_open` is 0 is dropped, and `cfg_wr_valid` stays 0.
- R6: `ltssm_en` stays 0 for as long as the first configuration window is open.
- R7: At the edge that samples `cfg_done` = 1 in the first window, `cfg_open` goes to 0 and `app_retry` takes the value of `late_cfg_req`. `ltssm_en` goes to 1 one edge later, so the retry control is raised before training starts.
- R8: Training-state codes other than 0x11 have no effect. At the edge that samples 0x11, `done` goes to 1 if no late configuration was requested. Otherwise `cfg_open` goes to 1 and `app_retry` stays 1.
- R9: If link-up is not seen, `err` goes to 1 at the (link_tmo+1)-th edge after the edge that set `ltssm_en`. At that same edge `ltssm_en` and `app_retry` go to 0.
- R10: In the late-configuration window, the edge that samples `cfg_done` = 1 clears `app_retry` and `cfg_open` and sets `done`. `done` is never 1 while `app_retry` is 1.
- R11: `err` stays 1 until reset, and `done` stays 0 after an error.
- R12: `ob_allow` is 1 exactly when `done` is 1 and `bus_master_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_locked | input | 1 | PHY PLL lock status |
| ltssm_state | input | LTSSM_W (6) | Training state code from the controller |
| pll_tmo | input | TMO_W (16) | PLL-lock wait limit in cycles |
| link_tmo | input | TMO_W (16) | Link-up wait limit in cycles |
| late_cfg_req | input | 1 | Request late configuration under retry, sampled with `cfg_done` |
| cfg_done | input | 1 | Closes the open configuration window |
| bus_master_en | input | 1 | Host has granted bus-master capability |
| cfg_in_valid | input | 1 | Configuration write request |
| cfg_in_addr | input | AW (8) | Configuration write address |
| cfg_in_data | input | DW (32) | Configuration write data |
| ctl_devtype | output | DT_W (4) | Device-type control to the controller |
| ctl_rst_n | output | 1 | Controller reset release |
| pll_en | output | 1 | PLL enable |
| pll_mult | output | MULT_W (10) | PLL multiplier value |
| ltssm_en | output | 1 | Link training enable |
| app_retry | output | 1 | Answer host requests with retry |
| cfg_open | output | 1 | Configuration window open |
| cfg_wr_valid | output | 1 | Forwarded write valid |
| cfg_wr_addr | output | AW (8) | Forwarded write address |
| cfg_wr_data | output | DW (32) | Forwarded write data |
| done | output | 1 | Bring-up complete |
| err | output | 1 | Timeout error, held until reset |
| ob_allow | output | 1 | Outbound transactions permitted |

## Verification
The assertions take for granted that `pll_locked` holds at 1 once it has risen, since the lock check looks back only one cycle. They also assume `cfg_done` is a pulse that the environment raises only inside an open window. The stimulus respects both: it raises `pll_locked` once per bring-up and keeps it high until the next reset, and it pulses `cfg_done` for exactly one cycle while `cfg_open` is 1. Randomised lock and link delays never exceed the programmed limit in the runs that are meant to succeed. Only the directed timeout runs hold the wait condition false on purpose.

// File: rtl/ep_bringup_pkg.sv
package ep_bringup_pkg;

    typedef enum logic [3:0] {
        ST_MODE      = 4'd0,
        ST_RELEASE   = 4'd1,
        ST_PLL_ON    = 4'd2,
        ST_PLL_WAIT  = 4'd3,
        ST_CFG       = 4'd4,
        ST_TRAIN_ON  = 4'd5,
        ST_LINK_WAIT = 4'd6,
        ST_LATE_CFG  = 4'd7,
        ST_DONE      = 4'd8,
        ST_ERR       = 4'd9
    } seq_state_e;

endpackage

// File: rtl/ep_wait_timer.sv
module ep_wait_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != limit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == limit);

endmodule

// File: rtl/ep_cfg_gate.sv
module ep_cfg_gate #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_t;

    wr_t wr_d, wr_q;

    always_comb begin
        wr_d       = wr_q;
        wr_d.valid = in_valid && open;
        if (in_valid && open) begin
            wr_d.addr = in_addr;
            wr_d.data = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign out_valid = wr_q.valid;
    assign out_addr  = wr_q.addr;
    assign out_data  = wr_q.data;

endmodule

// File: rtl/ep_bringup_seq.sv
module ep_bringup_seq
    import ep_bringup_pkg::*;
#(
    parameter int          DT_W     = 4,
    parameter int          MULT_W   = 10,
    parameter int          LTSSM_W  = 6,
    parameter int          TMO_W    = 16,
    parameter int          AW       = 8,
    parameter int          DW       = 32,
    parameter logic [MULT_W-1:0]  PLL_MULT = 10'h1C9,
    parameter logic [LTSSM_W-1:0] LINK_UP  = 6'h11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pll_locked,
    input  logic [LTSSM_W-1:0] ltssm_state,
    input  logic [TMO_W-1:0]   pll_tmo,
    input  logic [TMO_W-1:0]   link_tmo,
    input  logic               late_cfg_req,
    input  logic               cfg_done,
    input  logic               bus_master_en,
    input  logic               cfg_in_valid,
    input  logic [AW-1:0]      cfg_in_addr,
    input  logic [DW-1:0]      cfg_in_data,
    output logic [DT_W-1:0]    ctl_devtype,
    output logic               ctl_rst_n,
    output logic               pll_en,
    output logic [MULT_W-1:0]  pll_mult,
    output logic               ltssm_en,
    output logic               app_retry,
    output logic               cfg_open,
    output logic               cfg_wr_valid,
    output logic [AW-1:0]      cfg_wr_addr,
    output logic [DW-1:0]      cfg_wr_data,
    output logic               done,
    output logic               err,
    output logic               ob_allow
);

    localparam logic [DT_W-1:0] DT_EP    = '0;
    localparam logic [DT_W-1:0] DT_RESET = '1;

    typedef struct packed {
        seq_state_e        state;
        logic [DT_W-1:0]   devtype;
        logic              ctl_rst_n;
        logic              pll_en;
        logic [MULT_W-1:0] pll_mult;
        logic              ltssm_en;
        logic              app_retry;
        logic              cfg_open;
        logic              late;
        logic              done;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             tmr_run;
    logic [TMO_W-1:0] tmr_limit;
    logic             tmr_expired;
    logic             link_up;

    assign tmr_run   = (seq_q.state == ST_PLL_WAIT) || (seq_q.state == ST_LINK_WAIT);
    assign tmr_limit = (seq_q.state == ST_LINK_WAIT) ? link_tmo : pll_tmo;
    assign link_up   = (ltssm_state == LINK_UP);

    ep_wait_timer #(
        .TMO_W (TMO_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    ep_cfg_gate #(
        .AW (AW),
        .DW (DW)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .open      (seq_q.cfg_open),
        .in_valid  (cfg_in_valid),
        .in_addr   (cfg_in_addr),
        .in_data   (cfg_in_data),
        .out_valid (cfg_wr_valid),
        .out_addr  (cfg_wr_addr),
        .out_data  (cfg_wr_data)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_MODE: begin
                seq_d.devtype = DT_EP;
                seq_d.state   = ST_RELEASE;
            end
            ST_RELEASE: begin
                seq_d.ctl_rst_n = 1'b1;
                seq_d.state     = ST_PLL_ON;
            end
            ST_PLL_ON: begin
                seq_d.pll_en   = 1'b1;
                seq_d.pll_mult = PLL_MULT;
                seq_d.state    = ST_PLL_WAIT;
            end
            ST_PLL_WAIT: begin
                if (pll_locked) begin
                    seq_d.cfg_open = 1'b1;
                    seq_d.state    = ST_CFG;
                end else if (tmr_expired) begin
                    seq_d.err   = 1'b1;
                    seq_d.state = ST_ERR;
                end
            end
            ST_CFG: begin
                if (cfg_done) begin
                    seq_d.cfg_open  = 1'b0;
                    seq_d.late      = late_cfg_req;
                    seq_d.app_retry = late_cfg_req;
                    seq_d.state     = ST_TRAIN_ON;
                end
            end
            ST_TRAIN_ON: begin
                seq_d.ltssm_en = 1'b1;
                seq_d.state    = ST_LINK_WAIT;
            end
            ST_LINK_WAIT: begin
                if (link_up) begin
                    if (seq_q.late) begin
                        seq_d.cfg_open = 1'b1;
                        seq_d.state    = ST_LATE_CFG;
                    end else begin
                        seq_d.done  = 1'b1;
                        seq_d.state = ST_DONE;
                    end
                end else if (tmr_expired) begin
                    seq_d.err       = 1'b1;
                    seq_d.ltssm_en  = 1'b0;
                    seq_d.app_retry = 1'b0;
                    seq_d.state     = ST_ERR;
                end
            end
            ST_LATE_CFG: begin
                if (cfg_done) begin
                    seq_d.cfg_open  = 1'b0;
                    seq_d.app_retry = 1'b0;
                    seq_d.done      = 1'b1;
                    seq_d.state     = ST_DONE;
                end
            end
            ST_DONE: begin
                seq_d.state = ST_DONE;
            end
            ST_ERR: begin
                seq_d.state = ST_ERR;
            end
            default: begin
                seq_d.err       = 1'b1;
                seq_d.done      = 1'b0;
                seq_d.ltssm_en  = 1'b0;
                seq_d.app_retry = 1'b0;
                seq_d.cfg_open  = 1'b0;
                seq_d.state     = ST_ERR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q           <= '0;
            seq_q.state     <= ST_MODE;
            seq_q.devtype   <= DT_RESET;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ctl_devtype = seq_q.devtype;
    assign ctl_rst_n   = seq_q.ctl_rst_n;
    assign pll_en      = seq_q.pll_en;
    assign pll_mult    = seq_q.pll_mult;
    assign ltssm_en    = seq_q.ltssm_en;
    assign app_retry   = seq_q.app_retry;
    assign cfg_open    = seq_q.cfg_open;
    assign done        = seq_q.done;
    assign err         = seq_q.err;
    assign ob_allow    = seq_q.done && bus_master_en;

endmodule

// File: rtl/ep_bringup_chk.sv
module ep_bringup_chk #(
    parameter int DT_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [DT_W-1:0] ctl_devtype,
    input logic            ctl_rst_n,
    input logic            pll_locked,
    input logic            cfg_open,
    input logic            cfg_wr_valid,
    input logic            app_retry,
    input logic            ltssm_en,
    input logic            done,
    input logic            err
);

    a_r1_ep_code_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_n |-> (ctl_devtype == '0));

    a_r3_lock_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cfg_open) && !app_retry) |-> $past(pll_locked));

    a_r5_forward_only_open: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_valid |-> $past(cfg_open));

    a_r6_train_off_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && !app_retry) |-> !ltssm_en);

    a_r7_retry_before_train: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(app_retry) |-> !ltssm_en);

    a_r10_retry_release_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(app_retry) && !err) |-> done);

    a_r10_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ltssm_en && !app_retry && !err));

    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && !done));

endmodule

bind ep_bringup_seq ep_bringup_chk #(
    .DT_W (DT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_devtype  (ctl_devtype),
    .ctl_rst_n    (ctl_rst_n),
    .pll_locked   (pll_locked),
    .cfg_open     (cfg_open),
    .cfg_wr_valid (cfg_wr_valid),
    .app_retry    (app_retry),
    .ltssm_en     (ltssm_en),
    .done         (done),
    .err          (err)
);

// File: tb/ep_bringup_seq_bench.sv
module ep_bringup_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pll_locked;
    logic [5:0]  ltssm_state;
    logic [15:0] pll_tmo, link_tmo;
    logic        late_cfg_req, cfg_done, bus_master_en;
    logic        cfg_in_valid;
    logic [7:0]  cfg_in_addr;
    logic [31:0] cfg_in_data;
    logic [3:0]  ctl_devtype;
    logic        ctl_rst_n, pll_en, ltssm_en, app_retry, cfg_open;
    logic [9:0]  pll_mult;
    logic        cfg_wr_valid;
    logic [7:0]  cfg_wr_addr;
    logic [31:0] cfg_wr_data;
    logic        done, err, ob_allow;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ep_bringup_seq u_ep_bringup_seq (
        .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .ltssm_state(ltssm_state),
        .pll_tmo(pll_tmo), .link_tmo(link_tmo), .late_cfg_req(late_cfg_req),
        .cfg_done(cfg_done), .bus_master_en(bus_master_en), .cfg_in_valid(cfg_in_valid),
        .cfg_in_addr(cfg_in_addr), .cfg_in_data(cfg_in_data), .ctl_devtype(ctl_devtype),
        .ctl_rst_n(ctl_rst_n), .pll_en(pll_en), .pll_mult(pll_mult), .ltssm_en(ltssm_en),
        .app_retry(app_retry), .cfg_open(cfg_open), .cfg_wr_valid(cfg_wr_valid),
        .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data), .done(done), .err(err),
        .ob_allow(ob_allow)
    );

    function automatic int exp_tmo_edges(input int limit);
        return limit + 1;
    endfunction

    function automatic bit exp_ob(input bit d, input bit bme);
        return d && bme;
    endfunction

    function automatic logic [5:0] non_linkup_code();
        logic [5:0] c;
        c = 6'($urandom_range(0, 63));
        if (c == 6'h11) c = 6'h10;
        return c;
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic write_once(input bit expect_fwd, input string rq);
        logic [7:0]  a;
        logic [31:0] d;
        a = 8'($urandom);
        d = $urandom;
        cfg_in_valid = 1'b1;
        cfg_in_addr  = a;
        cfg_in_data  = d;
        tick();
        cfg_in_valid = 1'b0;
        chk(cfg_wr_valid == expect_fwd, rq, cfg_wr_valid, expect_fwd);
        if (expect_fwd) begin
            chk(cfg_wr_addr == a && cfg_wr_data == d, rq, cfg_wr_data, d);
        end
    endtask

    // mode: 0 success, 1 pll timeout, 2 link timeout
    task automatic bring_up(input int mode, input bit late, input int pll_dly,
                            input int link_dly, input int plim, input int llim);
        int k;
        pll_tmo = 16'(plim);
        link_tmo = 16'(llim);
        rst_n = 1'b0;
        pll_locked = 1'b0;
        ltssm_state = 6'h00;
        late_cfg_req = 1'b0;
        cfg_done = 1'b0;
        bus_master_en = 1'b1;
        cfg_in_valid = 1'b0;
        tick();
        tick();
        // R1 reset state
        chk(ctl_devtype == 4'hF && !ctl_rst_n && !pll_en && !ltssm_en && !app_retry &&
            !cfg_open && !done && !err && !ob_allow && !cfg_wr_valid,
            "R1 reset", ctl_devtype, 4'hF);
        rst_n = 1'b1;
        tick();
        chk(ctl_devtype == 4'h0 && !ctl_rst_n, "R1 endpoint code first", ctl_devtype, 0);
        tick();
        chk(ctl_rst_n && !pll_en, "R2 release after mode", ctl_rst_n, 1);
        tick();
        chk(pll_en && pll_mult == 10'h1C9, "R2 pll multiplier", pll_mult, 10'h1C9);

        if (mode == 1) begin
            cfg_in_valid = 1'b1;
            for (k = 1; k <= plim + 4; k++) begin
                tick();
                if (err) break;
            end
            cfg_in_valid = 1'b0;
            chk(k == exp_tmo_edges(plim), "R4 pll timeout edge", k, exp_tmo_edges(plim));
            chk(!cfg_open && !done && !cfg_wr_valid, "R5 no window on pll error", cfg_open, 0);
            tick();
            tick();
            chk(err && !done && !ob_allow, "R11 error sticky", err, 1);
            return;
        end

        // R3/R5 waiting for lock, writes dropped
        for (int i = 0; i < pll_dly; i++) begin
            write_once(1'b0, "R5 write dropped in pll wait");
            chk(!cfg_open && !err, "R3 wait for lock", cfg_open, 0);
        end
        pll_locked = 1'b1;
        write_once(1'b0, "R5 write at lock edge dropped");
        chk(cfg_open && !ltssm_en, "R3 window after lock", cfg_open, 1);

        for (int i = 0; i < 1 + int'($urandom_range(0, 3)); i++) begin
            write_once(1'b1, "R5 write forwarded");
            chk(!ltssm_en, "R6 training off in window", ltssm_en, 0);
        end
        tick();
        chk(!ltssm_en && !cfg_wr_valid, "R6 idle window", ltssm_en, 0);

        late_cfg_req = late;
        cfg_done = 1'b1;
        tick();
        cfg_done = 1'b0;
        late_cfg_req = 1'b0;
        chk(app_retry == late && !ltssm_en && !cfg_open, "R7 retry before training", app_retry, late);
        write_once(1'b0, "R5 write dropped after close");
        chk(ltssm_en, "R7 training enabled", ltssm_en, 1);

        if (mode == 2) begin
            for (k = 1; k <= llim + 4; k++) begin
                ltssm_state = non_linkup_code();
                tick();
                if (err) break;
            end
            chk(k == exp_tmo_edges(llim), "R9 link timeout edge", k, exp_tmo_edges(llim));
            chk(!ltssm_en && !app_retry && !done, "R9 controls dropped", ltssm_en, 0);
            ltssm_state = 6'h11;
            tick();
            tick();
            chk(err && !done && !ob_allow, "R11 error sticky", done, 0);
            return;
        end

        for (int i = 0; i < link_dly; i++) begin
            ltssm_state = non_linkup_code();
            tick();
            chk(!done && !cfg_open && !err, "R8 other codes ignored", done, 0);
        end
        ltssm_state = 6'h11;
        tick();
        if (!late) begin
            chk(done && !app_retry, "R8 done on link-up", done, 1);
        end else begin
            chk(cfg_open && app_retry && !done, "R8 late window opens", cfg_open, 1);
            bus_master_en = 1'b1;
            write_once(1'b1, "R5 late write forwarded");
            chk(app_retry && !done && !ob_allow, "R10 retry held", app_retry, 1);
            cfg_done = 1'b1;
            tick();
            cfg_done = 1'b0;
            chk(done && !app_retry && !cfg_open, "R10 retry cleared with done", app_retry, 0);
        end
        bus_master_en = 1'b0;
        tick();
        chk(ob_allow == exp_ob(done, 1'b0), "R12 no grant", ob_allow, 0);
        bus_master_en = 1'b1;
        tick();
        chk(ob_allow == exp_ob(done, 1'b1), "R12 granted", ob_allow, 1);
        chk(!err, "R11 no error on success", err, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        pll_locked = 1'b0;
        ltssm_state = '0;
        pll_tmo = '0;
        link_tmo = '0;
        late_cfg_req = 1'b0;
        cfg_done = 1'b0;
        bus_master_en = 1'b0;
        cfg_in_valid = 1'b0;
        cfg_in_addr = '0;
        cfg_in_data = '0;

        bring_up(0, 1'b0, 0, 0, 4, 4);
        bring_up(0, 1'b1, 2, 3, 6, 6);
        bring_up(0, 1'b0, 5, 7, 5, 7);   // delays equal to limits
        bring_up(1, 1'b0, 0, 0, 0, 4);   // zero pll limit
        bring_up(1, 1'b0, 0, 0, 9, 4);
        bring_up(2, 1'b1, 1, 0, 4, 3);   // link timeout with retry up
        bring_up(2, 1'b0, 0, 0, 4, 0);
        for (int r = 0; r < 8; r++) begin
            int pl, ll;
            pl = int'($urandom_range(2, 20));
            ll = int'($urandom_range(2, 20));
            bring_up(0, 1'($urandom_range(0, 1)), int'($urandom_range(0, pl)),
                     int'($urandom_range(0, ll)), pl, ll);
        end
        finish_run();
    end

endmodule